// File: doc/BRIEF.md
# Power-On Reset and Watchdog Reset Generator

This block produces the active-low processor reset and the divided clock enables for a small microprocessor system. It takes a power-good level from an external voltage comparator, a free-running clock, and a single-cycle watchdog-clear strobe from the processor.

While power-good is low, the block clears its clock divider, so no enables are produced. It also pulls the reset output low at once, without waiting for a clock edge. When power-good rises, the level passes through a two-stage synchronizer, and then the divider starts running. A watchdog counter advances on one of the divider's enables. When it reaches its terminal count, it pulses and wraps to zero.

The reset output is a flip-flop that toggles on every terminal pulse. The first pulse after power-up releases the processor. From then on, the processor must strobe watchdog-clear before each terminal count. If it stops, reset toggles at a fixed period and so forms a repeating reset pulse train.

Top module: `por_watchdog`

## Requirements
- R1: While `pwr_ok_i` is low, every bit of `clk_en_o` is 0.
- R2: When `pwr_ok_i` falls, `rst_n_o` goes to 0 without waiting for a clock edge, and it stays 0 while `pwr_ok_i` is low.
- R3: Once running, `clk_en_o[k]` is high for exactly one clock in every 2^(k+1) clocks. It is high when the low k+1 bits of the divider count are all ones.
- R4: The divider has a two-stage power-good synchronizer ahead of it. After `pwr_ok_i` rises between clock edges, `clk_en_o[0]` is first high in the cycle that follows the third rising edge.
- R5: The watchdog counter advances on `clk_en_o[WD_SEL]`. Its terminal count is WD_TC ticks. After power-up, `rst_n_o` first goes high right after rising edge number 2 + 2^(WD_SEL+1)*WD_TC. With the defaults this is edge 66.
- R6: A `wd_clr_i` strobe returns the watchdog count to zero. Strobes spaced closer than 2^(WD_SEL+1)*WD_TC clocks keep `rst_n_o` high indefinitely.
- R7: If `wd_clr_i` is high in the same cycle as a terminal tick, the clear wins, and `rst_n_o` does not toggle at that edge.
- R8: Without strobes, `rst_n_o` toggles once every 2^(WD_SEL+1)*WD_TC clocks. It changes only at an edge where `clk_en_o[WD_SEL]` was high.
- R9: `wd_clr_i` has no effect while `pwr_ok_i` is low. `rst_n_o` stays 0 and `clk_en_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock |
| pwr_ok_i | input | 1 | Power-good level from the comparator, asynchronous |
| wd_clr_i | input | 1 | Single-cycle watchdog-clear strobe from the processor |
| clk_en_o | output | DIV_W | Divided clock enables; bit k divides by 2^(k+1) |
| rst_n_o | output | 1 | Active-low processor reset |

## Verification
The bench goes after the exact release edge after power-up. A synchronizer that is one stage short or long, or a terminal count that is off by one, moves that edge, and the bench sees the shift.

It places a clear strobe precisely on a terminal tick. A design that let counting win over the clear would drop reset there.

It also cuts power midway through a reset pulse train. A synchronous-only assertion of reset would leave `rst_n_o` high until the next edge.

The bench times the free-running toggle period after the strobes stop. A design that held reset low, instead of toggling it, would show no periodic release.

// File: rtl/por_wdog_pkg.sv
`timescale 1ns/1ps
package por_wdog_pkg;
  // True when the lowest n bits of v are all ones (n >= 1).
  function automatic logic low_ones(input logic [31:0] v, input int n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < n) r = r & v[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/por_sync.sv
`timescale 1ns/1ps
module por_sync (
  input  logic clk,
  input  logic arst_n,
  output logic sync_o
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= stg_d;
  end

  assign sync_o = stg_q[1];
endmodule

// File: rtl/por_clkdiv.sv
`timescale 1ns/1ps
module por_clkdiv
  import por_wdog_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run_i,
  output logic [DIV_W-1:0] en_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < DIV_W; k++) begin : g_en
    assign en_o[k] = low_ones(32'(cnt_q), k + 1);
  end
endmodule

// File: rtl/por_wdcnt.sv
`timescale 1ns/1ps
module por_wdcnt #(
  parameter int WD_TC = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic clr_i,
  output logic term_o
);
  localparam int WD_W = (WD_TC > 1) ? $clog2(WD_TC) : 1;
  localparam logic [WD_W-1:0] LAST = WD_W'(WD_TC - 1);

  logic [WD_W-1:0] wd_q;
  logic [WD_W-1:0] wd_d;
  logic            at_last;

  assign at_last = (wd_q == LAST);
  assign term_o  = tick_i && !clr_i && at_last;

  always_comb begin
    wd_d = wd_q;
    if (clr_i)        wd_d = '0;
    else if (tick_i)  wd_d = at_last ? '0 : wd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) wd_q <= '0;
    else         wd_q <= wd_d;
  end
endmodule

// File: rtl/por_watchdog.sv
`timescale 1ns/1ps
module por_watchdog #(
  parameter int DIV_W  = 4,
  parameter int WD_SEL = 1,
  parameter int WD_TC  = 16
) (
  input  logic             clk,
  input  logic             pwr_ok_i,
  input  logic             wd_clr_i,
  output logic [DIV_W-1:0] clk_en_o,
  output logic             rst_n_o
);
  logic pwr_sync;
  logic term;
  logic rst_q;
  logic rst_d;

  por_sync u_sync (
    .clk    (clk),
    .arst_n (pwr_ok_i),
    .sync_o (pwr_sync)
  );

  por_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .arst_n (pwr_ok_i),
    .run_i  (pwr_sync),
    .en_o   (clk_en_o)
  );

  por_wdcnt #(.WD_TC(WD_TC)) u_wd (
    .clk    (clk),
    .arst_n (pwr_ok_i),
    .tick_i (clk_en_o[WD_SEL]),
    .clr_i  (wd_clr_i),
    .term_o (term)
  );

  always_comb begin
    rst_d = rst_q ^ term;
  end

  always_ff @(posedge clk or negedge pwr_ok_i) begin
    if (!pwr_ok_i) rst_q <= 1'b0;
    else           rst_q <= rst_d;
  end

  assign rst_n_o = rst_q;
endmodule

// File: rtl/por_watchdog_chk.sv
`timescale 1ns/1ps
module por_watchdog_chk #(
  parameter int DIV_W  = 4,
  parameter int WD_SEL = 1
) (
  input logic             clk,
  input logic             pwr_ok_i,
  input logic             wd_clr_i,
  input logic [DIV_W-1:0] clk_en_o,
  input logic             rst_n_o
);
  // R1, R2, R9: power bad holds reset low and enables idle
  always_ff @(posedge clk) begin
    if (!pwr_ok_i) begin
      assert_pwrbad_quiet_R2: assert (!rst_n_o && (clk_en_o == '0));
    end
  end

  // R7: a clear strobe blocks any toggle at the edge that samples it
  assert_clr_priority_R7: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    wd_clr_i |=> $stable(rst_n_o));

  // R8: reset only changes after a watchdog tick
  assert_toggle_on_tick_R8: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    !$stable(rst_n_o) |-> $past(clk_en_o[WD_SEL]));

  // R3: the fastest enable never stays high two cycles running
  assert_en0_single_R3: assert property (@(posedge clk) disable iff (!pwr_ok_i)
    clk_en_o[0] |=> !clk_en_o[0]);
endmodule

bind por_watchdog por_watchdog_chk #(.DIV_W(DIV_W), .WD_SEL(WD_SEL)) u_chk (
  .clk      (clk),
  .pwr_ok_i (pwr_ok_i),
  .wd_clr_i (wd_clr_i),
  .clk_en_o (clk_en_o),
  .rst_n_o  (rst_n_o)
);

// File: tb/sim_por_watchdog.sv
`timescale 1ns/1ps
module sim_por_watchdog;
  localparam int DIV_W  = 4;
  localparam int WD_SEL = 1;
  localparam int WD_TC  = 16;
  localparam int TICKP  = 1 << (WD_SEL + 1);
  localparam int PERIOD = TICKP * WD_TC;
  localparam int DIVMOD = 1 << DIV_W;

  logic             clk = 1'b0;
  logic             pwr_ok_i;
  logic             wd_clr_i;
  logic [DIV_W-1:0] clk_en_o;
  logic             rst_n_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  int m_s1 = 0, m_s2 = 0, m_div = 0, m_wd = 0, m_rst = 0;

  always #4 clk = ~clk;

  por_watchdog #(.DIV_W(DIV_W), .WD_SEL(WD_SEL), .WD_TC(WD_TC)) u0 (
    .clk(clk), .pwr_ok_i(pwr_ok_i), .wd_clr_i(wd_clr_i),
    .clk_en_o(clk_en_o), .rst_n_o(rst_n_o)
  );

  function automatic logic [DIV_W-1:0] exp_en(int d);
    logic [DIV_W-1:0] e;
    for (int k = 0; k < DIV_W; k++) begin
      int p;
      p = 1 << (k + 1);
      e[k] = ((d % p) == p - 1);
    end
    return e;
  endfunction

  task automatic model_clear();
    m_s1 = 0; m_s2 = 0; m_div = 0; m_wd = 0; m_rst = 0;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (pwr_ok_i === 1'b1) begin
      bit tick, term;
      int nwd;
      tick = (m_div % TICKP) == TICKP - 1;
      term = tick && !wd_clr_i && (m_wd == WD_TC - 1);
      nwd  = m_wd;
      if (wd_clr_i)  nwd = 0;
      else if (tick) nwd = (m_wd == WD_TC - 1) ? 0 : m_wd + 1;
      m_wd = nwd;
      if (term) m_rst = 1 - m_rst;
      if (m_s2 != 0) m_div = (m_div + 1) % DIVMOD;
      m_s2 = m_s1;
      m_s1 = 1;
    end else begin
      model_clear();
    end
  end

  // per-cycle comparison against the model (R1, R3, R5, R6, R7, R8)
  always @(negedge clk) begin
    #2;
    if (!done && cycles > 2) begin
      chk(clk_en_o == exp_en(m_div), "R3 clk_en_o vs model", int'(clk_en_o), int'(exp_en(m_div)));
      chk(int'(rst_n_o) == m_rst, "R8 rst_n_o vs model", int'(rst_n_o), m_rst);
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      summary();
    end
  end

  task automatic step();
    @(negedge clk);
    #3;
  endtask

  task automatic power_up_and_release(string tag);
    int n = 0, first_en = -1;
    pwr_ok_i = 1'b1;
    while (rst_n_o !== 1'b1 && n < 500) begin
      step();
      n++;
      if (first_en < 0 && clk_en_o[0] === 1'b1) first_en = n;
    end
    chk(first_en == 3, {"R4 first enable edge ", tag}, first_en, 3);
    chk(n == 2 + PERIOD, {"R5 release edge ", tag}, n, 2 + PERIOD);
  endtask

  initial begin
    pwr_ok_i = 1'b1;
    wd_clr_i = 1'b0;
    #2 pwr_ok_i = 1'b0;
    // power bad, with strobes that must be ignored
    for (int i = 0; i < 20; i++) begin
      step();
      wd_clr_i = (i % 3 == 0);
      chk(rst_n_o === 1'b0, "R9 reset low under strobes", int'(rst_n_o), 0);
      chk(clk_en_o === '0, "R1 enables idle", int'(clk_en_o), 0);
    end
    wd_clr_i = 1'b0;
    step();
    chk(rst_n_o === 1'b0, "R2 reset low while power bad", int'(rst_n_o), 0);

    power_up_and_release("first");

    // strobe exactly on the next terminal tick
    for (int i = 0; i < PERIOD - 1; i++) step();
    wd_clr_i = 1'b1;
    step();
    wd_clr_i = 1'b0;
    chk(rst_n_o === 1'b1, "R7 clear beats terminal tick", int'(rst_n_o), 1);

    // regular strobes keep reset high
    for (int s = 0; s < 50; s++) begin
      wd_clr_i = 1'b1;
      step();
      wd_clr_i = 1'b0;
      for (int i = 0; i < 39; i++) begin
        step();
        if (rst_n_o !== 1'b1) chk(0, "R6 reset held high", int'(rst_n_o), 1);
      end
    end
    chk(rst_n_o === 1'b1, "R6 reset high after strobes", int'(rst_n_o), 1);

    // stop strobing: reset starts toggling with a fixed period
    begin
      int n = 0;
      logic prev;
      while (rst_n_o === 1'b1 && n < 2 * PERIOD) begin step(); n++; end
      chk(n <= PERIOD, "R8 first drop after strobes stop", n, PERIOD);
      for (int t = 0; t < 4; t++) begin
        prev = rst_n_o;
        n = 0;
        while (rst_n_o === prev && n < 2 * PERIOD) begin step(); n++; end
        chk(n == PERIOD, "R8 toggle period", n, PERIOD);
      end
    end

    // power drop mid pulse train: reset must fall with no clock edge
    while (rst_n_o !== 1'b1) step();
    @(negedge clk);
    pwr_ok_i = 1'b0;
    model_clear();
    #1;
    chk(rst_n_o === 1'b0, "R2 asynchronous assertion", int'(rst_n_o), 0);
    chk(clk_en_o === '0, "R1 divider cleared on power loss", int'(clk_en_o), 0);
    for (int i = 0; i < 10; i++) step();

    power_up_and_release("second");
    for (int i = 0; i < 10; i++) step();
    summary();
  end
endmodule